// File: doc/BRIEF.md
# Two-Bit-Per-Cell Memory Access Sequencer

This block is the digital sequencer for a memory in which every cell holds two bits as one of four analog levels. Each word spans 16 cells, and the word is spread over two storage arrays. A write places a level on every column in one clock. The level comes from a choice of bitline switch, which sets how many unit capacitors are precharged and how many are predischarged before they share charge. A read never senses a level directly. The sequencer writes a reference level into a reference row of the opposite array, and the sense amplifiers then compare each cell against that reference. This happens twice: the first comparison gives the upper bit and the second gives the lower bit.

A read runs in four cycles: reference write, compare, reference write, compare. The first reference is the middle one and is the same on all columns. For the second reference, each column uses the upper bit it has just resolved to choose either the high or the low reference. The analog bitlines, the replica timing and the sense amplifiers are outside this block. The block only drives their enables and receives one comparison bit per column on `cmp_in`. All control outputs are registered, so they hold steady for the whole cycle.

Switch numbering: each column has seven level switches, indexed k = 0..6. Switch k gives a split of (k+5) precharged to (7−k) predischarged capacitors.

Top module: `mlc_access_ctrl`

## Requirements
- R1: When reset is held, and in idle, every decoder enable, pull-up, pull-down, switch select, sense enable and control enable is 0, and `rd_valid` is 0.
- R2: In idle with `wr_en` high, the next cycle is a write cycle, even if `rd_en` is also high. In that cycle `addr_dec_en` is 2'b01 when addr[7]=0 and 2'b10 when addr[7]=1, `row_sel` = addr[6:0], `pu_en`, `pd_en` and `wr_ctl_en` are 1, and `sa_en` and `ref_dec_en` are 0.
- R3: In a write cycle, column c (data bits [2c+1:2c] = v) has only switch bit 7c+2v set.
- R4: While `wr_en` stays high, write cycles follow back to back, and each one takes the address and data present at its launching edge.
- R5: In idle with `rd_en` high and `wr_en` low, the next cycle is a reference write. In it `ref_dec_en` selects the array opposite addr[7], `addr_dec_en` is 0, `ref_row` = `ref_addr`, `pu_en`, `pd_en` and `wr_ctl_en` are 1, and every column selects switch 3 (middle reference). A reference write is always followed by a compare cycle.
- R6: In a compare cycle, `addr_dec_en` selects the data array and `ref_dec_en` selects the other one, `sa_en` and `rd_ctl_en` are 1, and `pu_en`, `pd_en` and all switch bits are 0. Address and reference row stay as launched, even if the inputs change.
- R7: In the second reference write, column c selects switch 5 (high reference) if its first comparison bit was 1, and switch 1 (low reference) if it was 0.
- R8: A read takes exactly four cycles. In the cycle after the second compare, `rd_valid` is 1 for that cycle only, `rd_data` holds the second comparison bits and `rd_msb` holds the first.
- R9: After the second compare, and after a write cycle, the next cycle is chosen the same way as from idle: write if `wr_en`, else reference write if `rd_en`, else idle.
- R10: At most one switch bit per column is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request (wins over read) |
| addr | input | 8 | Bit 7 picks the data array, bits 6:0 the row |
| ref_addr | input | 2 | Reference row used during a read |
| wr_data | input | 32 | Two bits per column, column c at [2c+1:2c] |
| cmp_in | input | 16 | Per-column comparison result (cell above reference) |
| arr_sel | output | 2 | One-hot select of the data array |
| row_sel | output | 7 | Row predecode to the address decoder |
| addr_dec_en | output | 2 | Address decoder enable per array |
| ref_dec_en | output | 2 | Reference decoder enable per array |
| ref_row | output | 2 | Reference row to the reference decoder |
| pu_en | output | 1 | Bitline pull-up enable |
| pd_en | output | 1 | Bitline pull-down enable |
| sw_sel | output | 112 | Seven one-hot level switch selects per column |
| sa_en | output | 1 | Sense amplifier enable |
| wr_ctl_en | output | 1 | Write control enable |
| rd_ctl_en | output | 1 | Read control enable |
| rd_data | output | 16 | Lower bit per column of the last read |
| rd_msb | output | 16 | Upper bit per column of the last read |
| rd_valid | output | 1 | One-cycle pulse marking a finished read |

## Verification
The hardest situation to reach is the second reference write with a mix of high and low choices across the columns. The per-column choice depends on comparison bits that come back from outside the block. The bench therefore includes a small model of the array. It remembers each written word, captures the reference switches that the sequencer drives, and returns to `cmp_in` whether each stored level lies above the chosen reference. Stored patterns that put all four values in different columns then exercise both reference choices in the same cycle. Directed sequences also cover write priority, a read launched directly from a write, a write launched directly from the end of a read, and a reset in the middle of a read.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    localparam int unsigned MLC_COLS   = 16;
    localparam int unsigned MLC_ROW_W  = 7;
    localparam int unsigned MLC_REF_W  = 2;
    // number of level switches per column; switch k gives (k+5):(7-k)
    localparam int unsigned MLC_LEVELS = 7;

    localparam int unsigned K_REF_LOW  = 1;
    localparam int unsigned K_REF_MID  = 3;
    localparam int unsigned K_REF_HIGH = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WDATA = 2'd1,
        ST_WREF  = 2'd2,
        ST_READ  = 2'd3
    } mlc_state_e;

    typedef enum logic [1:0] {
        SW_OFF,
        SW_DATA,
        SW_REF_MID,
        SW_REF_SPLIT
    } sw_src_e;

    typedef struct packed {
        logic [1:0] arr_sel;
        logic [1:0] addr_dec_en;
        logic [1:0] ref_dec_en;
        logic       pu_en;
        logic       pd_en;
        logic       wr_ctl_en;
        logic       rd_ctl_en;
        logic       sa_en;
    } mlc_ctl_t;

    function automatic logic [MLC_LEVELS-1:0] k_onehot(input int unsigned k);
        return {{(MLC_LEVELS-1){1'b0}}, 1'b1} << k;
    endfunction

    // storage values sit on even switches: value v -> switch 2v
    function automatic int unsigned data_k(input logic [1:0] v);
        return {29'd0, v, 1'b0};
    endfunction

    function automatic logic [1:0] arr_onehot(input logic hi);
        return hi ? 2'b10 : 2'b01;
    endfunction

    function automatic mlc_state_e launch_state(input logic rd, input logic wr);
        if (wr)      return ST_WDATA;
        else if (rd) return ST_WREF;
        else         return ST_IDLE;
    endfunction

endpackage

// File: rtl/mlc_fsm.sv
module mlc_fsm
    import mlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  logic       wr_en,
    output mlc_state_e state_q,
    output logic       phase_q,
    output mlc_state_e state_d,
    output logic       phase_d
);

    always_comb begin
        state_d = state_q;
        phase_d = 1'b0;
        case (state_q)
            ST_IDLE, ST_WDATA: state_d = launch_state(rd_en, wr_en);
            ST_WREF: begin
                state_d = ST_READ;
                phase_d = phase_q;
            end
            ST_READ: begin
                if (!phase_q) begin
                    state_d = ST_WREF;
                    phase_d = 1'b1;
                end else begin
                    state_d = launch_state(rd_en, wr_en);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    // R5
    wref_to_read_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WREF) |=> (state_q == ST_READ));

    // R8
    first_cmp_then_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ && !phase_q) |=> (state_q == ST_WREF && phase_q));

endmodule

// File: rtl/mlc_sw_enc.sv
module mlc_sw_enc
    import mlc_pkg::*;
#(
    parameter int unsigned COLS = MLC_COLS
) (
    input  sw_src_e                      src,
    input  logic [2*COLS-1:0]            data,
    input  logic [COLS-1:0]              msb,
    output logic [COLS*MLC_LEVELS-1:0]   sw
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [MLC_LEVELS-1:0] col_sw;
        always_comb begin
            case (src)
                SW_DATA:      col_sw = k_onehot(data_k(data[2*c +: 2]));
                SW_REF_MID:   col_sw = k_onehot(K_REF_MID);
                SW_REF_SPLIT: col_sw = k_onehot(msb[c] ? K_REF_HIGH : K_REF_LOW);
                default:      col_sw = '0;
            endcase
        end
        assign sw[c*MLC_LEVELS +: MLC_LEVELS] = col_sw;
    end

endmodule

// File: rtl/mlc_rd_capture.sv
module mlc_rd_capture
    import mlc_pkg::*;
#(
    parameter int unsigned COLS = MLC_COLS
) (
    input  logic            clk,
    input  logic            rst,
    input  mlc_state_e      state_q,
    input  logic            phase_q,
    input  logic [COLS-1:0] cmp,
    output logic [COLS-1:0] msb_q,
    output logic [COLS-1:0] lsb_q,
    output logic            valid_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            msb_q   <= '0;
            lsb_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (state_q == ST_READ) begin
                if (!phase_q) begin
                    msb_q <= cmp;
                end else begin
                    lsb_q   <= cmp;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

endmodule

// File: rtl/mlc_access_ctrl.sv
module mlc_access_ctrl
    import mlc_pkg::*;
#(
    parameter int unsigned COLS  = MLC_COLS,
    parameter int unsigned ROW_W = MLC_ROW_W,
    parameter int unsigned REF_W = MLC_REF_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd_en,
    input  logic                          wr_en,
    input  logic [ROW_W:0]                addr,
    input  logic [REF_W-1:0]              ref_addr,
    input  logic [2*COLS-1:0]             wr_data,
    input  logic [COLS-1:0]               cmp_in,
    output logic [1:0]                    arr_sel,
    output logic [ROW_W-1:0]              row_sel,
    output logic [1:0]                    addr_dec_en,
    output logic [1:0]                    ref_dec_en,
    output logic [REF_W-1:0]              ref_row,
    output logic                          pu_en,
    output logic                          pd_en,
    output logic [COLS*MLC_LEVELS-1:0]    sw_sel,
    output logic                          sa_en,
    output logic                          wr_ctl_en,
    output logic                          rd_ctl_en,
    output logic [COLS-1:0]               rd_data,
    output logic [COLS-1:0]               rd_msb,
    output logic                          rd_valid
);

    localparam int unsigned ADDR_W = ROW_W + 1;
    localparam int unsigned SW_W   = COLS * MLC_LEVELS;

    mlc_state_e state_q, state_d;
    logic       phase_q, phase_d;

    mlc_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .state_q (state_q),
        .phase_q (phase_q),
        .state_d (state_d),
        .phase_d (phase_d)
    );

    // a new access starts: take address and reference row from the pins
    logic              launch;
    logic [ADDR_W-1:0] addr_q, eff_addr;
    logic [REF_W-1:0]  ref_q, eff_ref;

    assign launch   = (state_d == ST_WDATA) || (state_d == ST_WREF && !phase_d);
    assign eff_addr = launch ? addr : addr_q;
    assign eff_ref  = launch ? ref_addr : ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ref_q  <= '0;
        end else if (launch) begin
            addr_q <= addr;
            ref_q  <= ref_addr;
        end
    end

    // level switch source for the cycle being entered
    sw_src_e           sw_src;
    logic [SW_W-1:0]   sw_d;

    always_comb begin
        case (state_d)
            ST_WDATA: sw_src = SW_DATA;
            ST_WREF:  sw_src = phase_d ? SW_REF_SPLIT : SW_REF_MID;
            default:  sw_src = SW_OFF;
        endcase
    end

    // second reference is entered only from the first compare, so the
    // live comparison bits are the upper bits of this read
    mlc_sw_enc #(.COLS(COLS)) u_sw_enc (
        .src  (sw_src),
        .data (wr_data),
        .msb  (cmp_in),
        .sw   (sw_d)
    );

    mlc_ctl_t         ctl_d, ctl_q;
    logic [1:0]       dsel;
    logic [ROW_W-1:0] row_d, row_q;
    logic [REF_W-1:0] refrow_d, refrow_q;
    logic [SW_W-1:0]  sw_q;

    assign dsel = arr_onehot(eff_addr[ROW_W]);

    always_comb begin
        ctl_d    = '0;
        row_d    = '0;
        refrow_d = '0;
        case (state_d)
            ST_WDATA: begin
                ctl_d.arr_sel     = dsel;
                ctl_d.addr_dec_en = dsel;
                ctl_d.pu_en       = 1'b1;
                ctl_d.pd_en       = 1'b1;
                ctl_d.wr_ctl_en   = 1'b1;
                row_d             = eff_addr[ROW_W-1:0];
            end
            ST_WREF: begin
                ctl_d.arr_sel     = dsel;
                ctl_d.ref_dec_en  = ~dsel;
                ctl_d.pu_en       = 1'b1;
                ctl_d.pd_en       = 1'b1;
                ctl_d.wr_ctl_en   = 1'b1;
                row_d             = eff_addr[ROW_W-1:0];
                refrow_d          = eff_ref;
            end
            ST_READ: begin
                ctl_d.arr_sel     = dsel;
                ctl_d.addr_dec_en = dsel;
                ctl_d.ref_dec_en  = ~dsel;
                ctl_d.rd_ctl_en   = 1'b1;
                ctl_d.sa_en       = 1'b1;
                row_d             = eff_addr[ROW_W-1:0];
                refrow_d          = eff_ref;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            row_q    <= '0;
            refrow_q <= '0;
            sw_q     <= '0;
        end else begin
            ctl_q    <= ctl_d;
            row_q    <= row_d;
            refrow_q <= refrow_d;
            sw_q     <= sw_d;
        end
    end

    mlc_rd_capture #(.COLS(COLS)) u_rd_capture (
        .clk     (clk),
        .rst     (rst),
        .state_q (state_q),
        .phase_q (phase_q),
        .cmp     (cmp_in),
        .msb_q   (rd_msb),
        .lsb_q   (rd_data),
        .valid_q (rd_valid)
    );

    assign arr_sel     = ctl_q.arr_sel;
    assign addr_dec_en = ctl_q.addr_dec_en;
    assign ref_dec_en  = ctl_q.ref_dec_en;
    assign pu_en       = ctl_q.pu_en;
    assign pd_en       = ctl_q.pd_en;
    assign wr_ctl_en   = ctl_q.wr_ctl_en;
    assign rd_ctl_en   = ctl_q.rd_ctl_en;
    assign sa_en       = ctl_q.sa_en;
    assign row_sel     = row_q;
    assign ref_row     = refrow_q;
    assign sw_sel      = sw_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sw_sel == '0 && !pu_en && !pd_en && !sa_en &&
                        addr_dec_en == 2'b00 && ref_dec_en == 2'b00 && !rd_valid));

    // R6
    sense_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        sa_en |-> (!pu_en && !pd_en && sw_sel == '0));

    // R5
    wref_then_sense_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl_en && ref_dec_en != 2'b00) |=> (sa_en && $stable(ref_row)));

    // R2
    decoder_split_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_dec_en & ref_dec_en) == 2'b00);

    for (genvar c = 0; c < COLS; c++) begin : g_col_chk
        // R10
        column_onehot_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(sw_sel[c*MLC_LEVELS +: MLC_LEVELS]));
    end

endmodule

// File: tb/mlc_access_ctrl_tb.sv
module mlc_access_ctrl_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         rd_en, wr_en;
    logic [7:0]   addr;
    logic [1:0]   ref_addr;
    logic [31:0]  wr_data;
    logic [15:0]  cmp_in;
    logic [1:0]   arr_sel, addr_dec_en, ref_dec_en, ref_row;
    logic [6:0]   row_sel;
    logic         pu_en, pd_en, sa_en, wr_ctl_en, rd_ctl_en, rd_valid;
    logic [111:0] sw_sel;
    logic [15:0]  rd_data, rd_msb;

    always #10 clk = ~clk;

    mlc_access_ctrl u_dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .ref_addr(ref_addr), .wr_data(wr_data), .cmp_in(cmp_in),
        .arr_sel(arr_sel), .row_sel(row_sel), .addr_dec_en(addr_dec_en),
        .ref_dec_en(ref_dec_en), .ref_row(ref_row), .pu_en(pu_en), .pd_en(pd_en),
        .sw_sel(sw_sel), .sa_en(sa_en), .wr_ctl_en(wr_ctl_en), .rd_ctl_en(rd_ctl_en),
        .rd_data(rd_data), .rd_msb(rd_msb), .rd_valid(rd_valid)
    );

    // ---------------- array stub ----------------
    logic [31:0]  mem [256];
    logic [31:0]  cur_word;
    logic [111:0] ref_hold;

    always @(posedge clk)
        if (wr_ctl_en && ref_dec_en != 2'b00) ref_hold <= sw_sel;

    function automatic logic [15:0] stub_cmp(input logic [31:0] w, input logic [111:0] h);
        logic [15:0] r;
        r = '0;
        for (int c = 0; c < 16; c++) begin
            int kref;
            kref = 0;
            for (int k = 0; k < 7; k++) if (h[c*7+k]) kref = k;
            r[c] = (2 * int'(w[2*c +: 2])) > kref;
        end
        return r;
    endfunction

    assign cmp_in = stub_cmp(cur_word, ref_hold);

    // ---------------- expected values ----------------
    function automatic logic [111:0] exp_data_sw(input logic [31:0] d);
        logic [111:0] r;
        r = '0;
        for (int c = 0; c < 16; c++) r[c*7 + 2*int'(d[2*c +: 2])] = 1'b1;
        return r;
    endfunction

    function automatic logic [111:0] exp_ref_sw(input logic [15:0] m, input bit mid);
        logic [111:0] r;
        r = '0;
        for (int c = 0; c < 16; c++) r[c*7 + (mid ? 3 : (m[c] ? 5 : 1))] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] hi_bits(input logic [31:0] d);
        logic [15:0] r;
        for (int c = 0; c < 16; c++) r[c] = d[2*c+1];
        return r;
    endfunction

    function automatic logic [15:0] lo_bits(input logic [31:0] d);
        logic [15:0] r;
        for (int c = 0; c < 16; c++) r[c] = d[2*c];
        return r;
    endfunction

    function automatic logic [1:0] sel_of(input logic b);
        return b ? 2'b10 : 2'b01;
    endfunction

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] quiet_vec();
        return {sw_sel, addr_dec_en, ref_dec_en, pu_en, pd_en, sa_en,
                wr_ctl_en, rd_ctl_en, rd_valid};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; rd_en = 1'b0; addr = a; wr_data = d;
        tick();
        chk(addr_dec_en == sel_of(a[7]) && row_sel == a[6:0] && pu_en && pd_en &&
            wr_ctl_en && !sa_en && ref_dec_en == 2'b00,
            "R2 write cycle controls", {addr_dec_en, row_sel, pu_en, wr_ctl_en, sa_en},
            {sel_of(a[7]), a[6:0], 1'b1, 1'b1, 1'b0});
        chk(sw_sel == exp_data_sw(d), "R3 storage switch select", sw_sel, exp_data_sw(d));
        mem[a] = d;
        wr_en = 1'b0;
        tick();
        chk(quiet_vec() == '0, "R9 idle after write", quiet_vec(), 0);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [1:0] ra);
        logic [31:0] w;
        w = mem[a];
        cur_word = w;
        rd_en = 1'b1; wr_en = 1'b0; addr = a; ref_addr = ra;
        tick();                                   // first reference write
        rd_en = 1'b0; addr = ~a; ref_addr = ~ra;  // pins move, access must not
        chk(ref_dec_en == sel_of(!a[7]) && addr_dec_en == 2'b00 && ref_row == ra &&
            pu_en && pd_en && wr_ctl_en, "R5 reference write controls",
            {ref_dec_en, addr_dec_en, ref_row}, {sel_of(!a[7]), 2'b00, ra});
        chk(sw_sel == exp_ref_sw('0, 1'b1), "R5 middle reference", sw_sel,
            exp_ref_sw('0, 1'b1));
        tick();                                   // first compare
        chk(addr_dec_en == sel_of(a[7]) && ref_dec_en == sel_of(!a[7]) && sa_en &&
            rd_ctl_en && !pu_en && !pd_en && sw_sel == '0 && row_sel == a[6:0] &&
            ref_row == ra, "R6 compare cycle controls",
            {addr_dec_en, ref_dec_en, sa_en, row_sel, ref_row},
            {sel_of(a[7]), sel_of(!a[7]), 1'b1, a[6:0], ra});
        tick();                                   // second reference write
        chk(sw_sel == exp_ref_sw(hi_bits(w), 1'b0), "R7 split reference per column",
            sw_sel, exp_ref_sw(hi_bits(w), 1'b0));
        tick();                                   // second compare
        chk(sa_en && !rd_valid, "R8 second compare before result", {sa_en, rd_valid}, 2'b10);
        tick();
        chk(rd_valid && rd_data == lo_bits(w) && rd_msb == hi_bits(w), "R8 read result",
            {rd_valid, rd_msb, rd_data}, {1'b1, hi_bits(w), lo_bits(w)});
        tick();
        chk(!rd_valid && !sa_en, "R8 valid is one cycle", {rd_valid, sa_en}, 0);
    endtask

    localparam logic [39:0] VEC [0:5] = '{
        {8'h00, 32'h0000_0000},
        {8'hFF, 32'hFFFF_FFFF},
        {8'h81, 32'hE4E4_E4E4},
        {8'h2A, 32'h1B1B_1B1B},
        {8'hC3, 32'h5A5A_A5A5},
        {8'h7E, 32'h0F0F_F0F0}
    };

    initial begin
        rst = 1'b1; rd_en = 1'b0; wr_en = 1'b0; addr = '0; ref_addr = '0;
        wr_data = '0; cur_word = '0;
        repeat (3) tick();
        chk(quiet_vec() == '0, "R1 reset state", quiet_vec(), 0);
        rst = 1'b0;
        tick();
        chk(quiet_vec() == '0, "R1 idle with no request", quiet_vec(), 0);

        for (int i = 0; i < 6; i++) begin
            do_write(VEC[i][39:32], VEC[i][31:0]);
            do_read(VEC[i][39:32], 2'(i));
        end

        // R2 priority of write over read
        wr_en = 1'b1; rd_en = 1'b1; addr = 8'h05; wr_data = 32'h3333_CCCC;
        tick();
        chk(wr_ctl_en && !sa_en && ref_dec_en == 2'b00 && addr_dec_en == 2'b01,
            "R2 write wins over read", {wr_ctl_en, sa_en, ref_dec_en}, 4'b1000);
        mem[8'h05] = 32'h3333_CCCC;
        // R4 back-to-back write with new address and data
        rd_en = 1'b0; addr = 8'h86; wr_data = 32'h9C63_36C9;
        tick();
        chk(row_sel == 7'h06 && addr_dec_en == 2'b10 && sw_sel == exp_data_sw(32'h9C63_36C9),
            "R4 back-to-back write", {row_sel, addr_dec_en, sw_sel},
            {7'h06, 2'b10, exp_data_sw(32'h9C63_36C9)});
        mem[8'h86] = 32'h9C63_36C9;
        // R9 read launched straight from a write
        wr_en = 1'b0; rd_en = 1'b1; ref_addr = 2'd3; cur_word = mem[8'h86];
        tick();
        chk(ref_dec_en == 2'b01 && wr_ctl_en && ref_row == 2'd3,
            "R9 write to reference write", {ref_dec_en, ref_row}, {2'b01, 2'd3});
        rd_en = 1'b0;
        tick(); tick(); tick();                   // compare, reference, compare
        wr_en = 1'b1; addr = 8'h10; wr_data = 32'h2718_2818;
        tick();
        chk(rd_valid && rd_data == lo_bits(32'h9C63_36C9) && rd_msb == hi_bits(32'h9C63_36C9),
            "R8 result before chained write", {rd_valid, rd_msb, rd_data},
            {1'b1, hi_bits(32'h9C63_36C9), lo_bits(32'h9C63_36C9)});
        chk(wr_ctl_en && addr_dec_en == 2'b01 && row_sel == 7'h10,
            "R9 second compare to write", {wr_ctl_en, addr_dec_en, row_sel},
            {1'b1, 2'b01, 7'h10});
        mem[8'h10] = 32'h2718_2818;
        wr_en = 1'b0;
        tick();

        // R1 reset in the middle of a read
        rd_en = 1'b1; addr = 8'h10; cur_word = mem[8'h10];
        tick();
        rd_en = 1'b0;
        tick();
        rst = 1'b1;
        tick();
        chk(quiet_vec() == '0, "R1 reset during read", quiet_vec(), 0);
        rst = 1'b0;
        tick(); tick();
        chk(quiet_vec() == '0, "R1 no stale result after reset", quiet_vec(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R8 actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule